// File: doc/BRIEF.md
# System Control Register with Privilege Gating

A 16-bit control register that sits on the peripheral register bus of a small microcontroller. Software reads and writes it as one word. The register holds three password-lock bits, a privileged spare bit, the test-port enable, the upper-program-half select, the code-data page select and an operation-done flag. The block decodes these bits into the select lines that the memory map and the pin multiplexer consume.

The block has two reset inputs. `por_ni` marks a power-on or power-fail reset and is asserted together with `rst_ni`. `rst_ni` alone is a warm reset. The three lock bits are set only by the power-on reset. A warm reset keeps their values, and every other bit returns to its default on either reset.

Bits 8 to 10 take a write only while `priv_i` is high. The done flag runs a handshake with the debug unit. When software writes it with 1 while the debug flag is set, the block sends one pulse that clears the flag and one pulse that requests a system reset. The done flag stays set until the debug unit acknowledges it.

Top module: `sysctl_reg`

## Requirements
- R1: After a power-on reset (`por_ni` and `rst_ni` both low), `rd_data_o` reads 0x0782. Bits 10, 9, 8, 7 and 1 are 1, and all other bits are 0.
- R2: A warm reset (`rst_ni` low, `por_ni` high) sets bits 10 and 7 to 1 and bits 5:2 to 0. Bits 1, 8 and 9 keep the values they had before the reset.
- R3: Bits 0, 6 and 15:11 always read 0. Writing 1 to any of them changes no other bit and does not make them read 1.
- R4: Bits 8, 9 and 10 are loaded from `wr_data_i` only when `wr_en_i` and `priv_i` are both high. A write with `priv_i` low leaves them unchanged.
- R5: Bits 1, 3, 4, 5 and 7 are loaded from `wr_data_i` on every write, whatever the value of `priv_i`.
- R6: Writing 1 to bit 2 sets the done flag. If `spe_i` is high in that write cycle, `sys_rst_req_o` and `spe_clr_o` are each high for exactly the next cycle. If `spe_i` is low in that cycle, neither output pulses.
- R7: Writing 0 to bit 2 has no effect. `done_ack_i` clears bit 2 on the next edge. When a write of 1 to bit 2 and `done_ack_i` occur in the same cycle, the write wins and bit 2 reads 1.
- R8: `tap_dis_o` is high exactly when bit 7 is 0.
- R9: `upper_pages_o` equals bit 3. A value of 1 maps pages P2/P3 into the upper program half, and 0 maps the utility ROM there.
- R10: `cd_byte_page_o` equals bits 5:4, where 0 to 3 select P0 to P3. `cd_word_pair_o` equals bit 5, where 0 selects pair P0/P1 and 1 selects pair P2/P3.
- R11: When `PROG_KB` is 64 or less, bits 3 and 5 read 0. When `PROG_KB` is 32 or less, bit 4 also reads 0. Writes to those bits are then ignored, and the outputs that decode them stay 0.
- R12: `app_lock_o`, `sys_lock_o` and `aux_lock_o` equal bits 1, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, all reset types |
| por_ni | input | 1 | Active-low power-on / power-fail reset marker |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data |
| priv_i | input | 1 | Privileged access in progress |
| done_ack_i | input | 1 | Debug unit acknowledges the done flag |
| spe_i | input | 1 | Current state of the external debug flag |
| rd_data_o | output | 16 | Register read value |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| spe_clr_o | output | 1 | One-cycle clear of the external debug flag |
| tap_dis_o | output | 1 | Disables the test-port pin functions |
| upper_pages_o | output | 1 | Maps upper program pages instead of the utility ROM |
| cd_byte_page_o | output | 2 | Code-data page selected in byte mode |
| cd_word_pair_o | output | 1 | Code-data page pair selected in word mode |
| app_lock_o | output | 1 | Application password lock |
| sys_lock_o | output | 1 | System password lock |
| aux_lock_o | output | 1 | Second privileged lock bit |

## Verification
The case hardest to reach is a lock bit that survives a warm reset. To show it, the lock bits must first be moved away from their power-on value by a privileged write, and then `rst_ni` must be pulsed while `por_ni` stays high. The bench does this in both directions, clearing and then restoring the locks. Two further cases only occur when inputs coincide. In one, a write of 1 to the done bit lands in the same cycle as `done_ack_i`. In the other, such a write coincides with `spe_i` high or low. The directed steps force both cases, and the random phase draws those inputs with high probability. A second instance sized for a 32 KB memory shows that the bits forced to zero ignore writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned B_APP    = 1;
  localparam int unsigned B_DONE   = 2;
  localparam int unsigned B_UPA    = 3;
  localparam int unsigned B_CDA0   = 4;
  localparam int unsigned B_CDA1   = 5;
  localparam int unsigned B_TAP    = 7;
  localparam int unsigned B_SYS    = 8;
  localparam int unsigned B_AUX    = 9;
  localparam int unsigned B_SPARE  = 10;
  localparam int unsigned UPA_MIN_KB  = 64;
  localparam int unsigned CDA0_MIN_KB = 32;
endpackage

// File: rtl/sysctl_lock_bits.sv
module sysctl_lock_bits (
  input  logic clk_i,
  input  logic por_ni,
  input  logic wr_en_i,
  input  logic wr_priv_i,
  input  logic app_d_i,
  input  logic sys_d_i,
  input  logic aux_d_i,
  output logic app_o,
  output logic sys_o,
  output logic aux_o
);
  // only the power-on reset touches these; warm reset keeps them
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      app_o <= 1'b1;
      sys_o <= 1'b1;
      aux_o <= 1'b1;
    end else begin
      if (wr_en_i) app_o <= app_d_i;
      if (wr_priv_i) begin
        sys_o <= sys_d_i;
        aux_o <= aux_d_i;
      end
    end
  end
endmodule

// File: rtl/sysctl_done_hs.sv
module sysctl_done_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic spe_i,
  output logic done_o,
  output logic rst_req_o,
  output logic spe_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      rst_req_o <= 1'b0;
      spe_clr_o <= 1'b0;
    end else begin
      if (set_i)      done_o <= 1'b1;   // write beats ack
      else if (ack_i) done_o <= 1'b0;
      rst_req_o <= set_i & spe_i;
      spe_clr_o <= set_i & spe_i;
    end
  end
endmodule

// File: rtl/sysctl_page_map.sv
module sysctl_page_map (
  input  logic       upa_i,
  input  logic [1:0] cda_i,
  output logic       upper_pages_o,
  output logic [1:0] byte_page_o,
  output logic       word_pair_o
);
  always_comb begin
    upper_pages_o = upa_i;
    byte_page_o   = cda_i;
    word_pair_o   = cda_i[1];
  end
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg #(
  parameter int unsigned PROG_KB = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        priv_i,
  input  logic        done_ack_i,
  input  logic        spe_i,
  output logic [15:0] rd_data_o,
  output logic        sys_rst_req_o,
  output logic        spe_clr_o,
  output logic        tap_dis_o,
  output logic        upper_pages_o,
  output logic [1:0]  cd_byte_page_o,
  output logic        cd_word_pair_o,
  output logic        app_lock_o,
  output logic        sys_lock_o,
  output logic        aux_lock_o
);
  import sysctl_pkg::*;

  localparam bit HAS_UPPER = PROG_KB > UPA_MIN_KB;
  localparam bit HAS_CDA0  = PROG_KB > CDA0_MIN_KB;

  logic rst_all_n, wr_priv;
  logic spare_q, tap_q, upa_q, done_q;
  logic [1:0] cda_q;
  logic unused_wr;

  assign rst_all_n = rst_ni & por_ni;
  assign wr_priv   = wr_en_i & priv_i;
  assign unused_wr = ^wr_data_i;

  sysctl_lock_bits u_locks (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .wr_en_i   (wr_en_i),
    .wr_priv_i (wr_priv),
    .app_d_i   (wr_data_i[B_APP]),
    .sys_d_i   (wr_data_i[B_SYS]),
    .aux_d_i   (wr_data_i[B_AUX]),
    .app_o     (app_lock_o),
    .sys_o     (sys_lock_o),
    .aux_o     (aux_lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      spare_q <= 1'b1;
      tap_q   <= 1'b1;
    end else begin
      if (wr_priv) spare_q <= wr_data_i[B_SPARE];
      if (wr_en_i) tap_q   <= wr_data_i[B_TAP];
    end
  end

  generate
    if (HAS_UPPER) begin : g_upper
      always_ff @(posedge clk_i or negedge rst_all_n) begin
        if (!rst_all_n) begin
          upa_q    <= 1'b0;
          cda_q[1] <= 1'b0;
        end else if (wr_en_i) begin
          upa_q    <= wr_data_i[B_UPA];
          cda_q[1] <= wr_data_i[B_CDA1];
        end
      end
    end else begin : g_no_upper
      assign upa_q    = 1'b0;
      assign cda_q[1] = 1'b0;
    end
    if (HAS_CDA0) begin : g_cda0
      always_ff @(posedge clk_i or negedge rst_all_n) begin
        if (!rst_all_n)   cda_q[0] <= 1'b0;
        else if (wr_en_i) cda_q[0] <= wr_data_i[B_CDA0];
      end
    end else begin : g_no_cda0
      assign cda_q[0] = 1'b0;
    end
  endgenerate

  sysctl_done_hs u_done (
    .clk_i     (clk_i),
    .rst_ni    (rst_all_n),
    .set_i     (wr_en_i & wr_data_i[B_DONE]),
    .ack_i     (done_ack_i),
    .spe_i     (spe_i),
    .done_o    (done_q),
    .rst_req_o (sys_rst_req_o),
    .spe_clr_o (spe_clr_o)
  );

  sysctl_page_map u_map (
    .upa_i         (upa_q),
    .cda_i         (cda_q),
    .upper_pages_o (upper_pages_o),
    .byte_page_o   (cd_byte_page_o),
    .word_pair_o   (cd_word_pair_o)
  );

  assign tap_dis_o = ~tap_q;

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[B_APP]   = app_lock_o;
    rd_data_o[B_DONE]  = done_q;
    rd_data_o[B_UPA]   = upa_q;
    rd_data_o[B_CDA0]  = cda_q[0];
    rd_data_o[B_CDA1]  = cda_q[1];
    rd_data_o[B_TAP]   = tap_q;
    rd_data_o[B_SYS]   = sys_lock_o;
    rd_data_o[B_AUX]   = aux_lock_o;
    rd_data_o[B_SPARE] = spare_q;
  end
endmodule

// File: rtl/sysctl_reg_sva.sv
module sysctl_reg_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        por_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic        priv_i,
  input logic        done_ack_i,
  input logic        spe_i,
  input logic [15:0] rd_data_o,
  input logic        sys_rst_req_o,
  input logic        spe_clr_o,
  input logic        tap_dis_o,
  input logic        upper_pages_o,
  input logic [1:0]  cd_byte_page_o,
  input logic        cd_word_pair_o,
  input logic        app_lock_o,
  input logic        sys_lock_o,
  input logic        aux_lock_o
);
  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rd_data_o[15:11] == 5'd0 && !rd_data_o[6] && !rd_data_o[0]);

  p_priv_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && !priv_i) |=> rd_data_o[10:8] == $past(rd_data_o[10:8]));

  p_req_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && wr_data_i[2] && spe_i) |=> (sys_rst_req_o && spe_clr_o));

  p_req_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    sys_rst_req_o |-> $past(wr_en_i && wr_data_i[2] && spe_i));

  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (done_ack_i && !(wr_en_i && wr_data_i[2])) |=> !rd_data_o[2]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && wr_data_i[2]) |=> rd_data_o[2]);

  p_tap_dis_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    tap_dis_o == !rd_data_o[7]);

  p_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    upper_pages_o == rd_data_o[3]);

  p_cda_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    cd_byte_page_o == rd_data_o[5:4] && cd_word_pair_o == rd_data_o[5]);

  p_locks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    {aux_lock_o, sys_lock_o, app_lock_o} == {rd_data_o[9:8], rd_data_o[1]});
endmodule

bind sysctl_reg sysctl_reg_sva u_sva (.*);

// File: tb/tb_sysctl_reg.sv
`timescale 1ns/1ps
module tb_sysctl_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        wr_en = 1'b0, priv = 1'b0, ack = 1'b0, spe = 1'b0;
  logic [15:0] wr_data = '0;

  logic [15:0] rd, rd_s;
  logic req, clr, tapd, upp, wpair, app, sys, aux;
  logic [1:0] bpage;
  logic req_s, clr_s, tapd_s, upp_s, wpair_s, app_s, sys_s, aux_s;
  logic [1:0] bpage_s;

  int checks = 0, errors = 0;
  logic [15:0] exp_r, exp_s;
  logic exp_req;

  localparam logic [15:0] SMALL_MASK = ~16'h0038;

  always #2.5 clk = ~clk;

  sysctl_reg #(.PROG_KB(128)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .priv_i(priv), .done_ack_i(ack), .spe_i(spe),
    .rd_data_o(rd), .sys_rst_req_o(req), .spe_clr_o(clr), .tap_dis_o(tapd),
    .upper_pages_o(upp), .cd_byte_page_o(bpage), .cd_word_pair_o(wpair),
    .app_lock_o(app), .sys_lock_o(sys), .aux_lock_o(aux));

  sysctl_reg #(.PROG_KB(32)) dut_small (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .priv_i(priv), .done_ack_i(ack), .spe_i(spe),
    .rd_data_o(rd_s), .sys_rst_req_o(req_s), .spe_clr_o(clr_s), .tap_dis_o(tapd_s),
    .upper_pages_o(upp_s), .cd_byte_page_o(bpage_s), .cd_word_pair_o(wpair_s),
    .app_lock_o(app_s), .sys_lock_o(sys_s), .aux_lock_o(aux_s));

  function automatic logic [15:0] nxt(logic [15:0] cur, logic we, logic [15:0] d,
                                      logic pv, logic ak);
    logic [15:0] n = cur;
    if (we) begin
      n[1] = d[1]; n[3] = d[3]; n[4] = d[4]; n[5] = d[5]; n[7] = d[7];
      if (pv) n[10:8] = d[10:8];
    end
    if (we && d[2]) n[2] = 1'b1;
    else if (ak)    n[2] = 1'b0;
    return n;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(logic ereq);
    chk("R1/R2/R3/R4/R5/R7 rd_data", rd, exp_r);
    chk("R6 sys_rst_req", {15'd0, req}, {15'd0, ereq});
    chk("R6 spe_clr", {15'd0, clr}, {15'd0, ereq});
    chk("R8 tap_dis", {15'd0, tapd}, {15'd0, ~exp_r[7]});
    chk("R9 upper_pages", {15'd0, upp}, {15'd0, exp_r[3]});
    chk("R10 byte_page/word_pair", {13'd0, bpage, wpair}, {13'd0, exp_r[5:4], exp_r[5]});
    chk("R12 lock outputs", {13'd0, aux, sys, app}, {13'd0, exp_r[9:8], exp_r[1]});
    chk("R11 small rd_data", rd_s, exp_s);
    chk("R11 small decode", {13'd0, upp_s, bpage_s}, 16'd0);
  endtask

  // called at a negedge; drives, clocks, checks at the next negedge
  task automatic step(logic we, logic [15:0] d, logic pv, logic ak, logic sp);
    wr_en = we; wr_data = d; priv = pv; ack = ak; spe = sp;
    exp_req = we & d[2] & sp;
    exp_r = nxt(exp_r, we, d, pv, ak);
    exp_s = nxt(exp_s, we, d, pv, ak) & SMALL_MASK;
    @(posedge clk);
    @(negedge clk);
    check_all(exp_req);
  endtask

  task automatic warm_reset();
    wr_en = 1'b0; ack = 1'b0; spe = 1'b0;
    rst_ni = 1'b0;
    exp_r = (exp_r & 16'h0302) | 16'h0480;   // R2: locks kept
    exp_s = (exp_s & 16'h0302) | 16'h0480;
    @(posedge clk); @(negedge clk);
    check_all(1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_r = 16'h0782; exp_s = 16'h0782;
    repeat (3) @(negedge clk);
    check_all(1'b0);                           // R1 during reset
    rst_ni = 1'b1; por_ni = 1'b1;
    @(negedge clk);
    check_all(1'b0);                           // R1 after release

    step(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0);    // R3 R4 R5: no priv, reserved ignored, no pulse
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0);    // R7: write 0 to done ignored
    step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);    // R7: ack clears
    step(1'b1, 16'h0004, 1'b1, 1'b1, 1'b1);    // R6 R7: set wins over ack, pulse
    step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1);    // R6: pulse lasts one cycle
    step(1'b1, 16'h0004, 1'b0, 1'b0, 1'b0);    // R6: spe low, no pulse
    step(1'b1, 16'h0010, 1'b1, 1'b0, 1'b0);    // R4: priv clears locks; R8 tap off; R10 page 1
    step(1'b1, 16'h0028, 1'b0, 1'b0, 1'b0);    // R9 R10: page 2
    warm_reset();                              // R2: locks stay 0
    step(1'b1, 16'h07BA, 1'b1, 1'b0, 1'b0);    // R4 R5: privileged set
    warm_reset();                              // R2: locks stay 1

    for (int i = 0; i < 1500; i++) begin
      logic [15:0] d = 16'($urandom);
      step(($urandom % 4) != 0, d, $urandom % 2 == 1, $urandom % 3 == 0,
           $urandom % 2 == 1);
      if (i % 400 == 399) warm_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule